// File: doc/BRIEF.md
# Nibble Frequency (Poker) Randomness Monitor

This block watches a serial random bit stream and judges each packet of 20,000 bits with the four-bit frequency test. It splits the accepted bits into contiguous, non-overlapping groups of four. That gives 5,000 groups per packet. For each of the 16 possible group values it keeps a 9-bit occurrence counter. When a packet closes, the block squares every counter, adds the squares, and checks the total against two integer bounds. It also checks that no single counter is larger than 428. The result is one pass/fail flag for each packet.

The counters are held in a small two-sector RAM. One sector collects the current packet. The other sector holds the finished packet. A post-processor reads each counter of the finished sector and clears it. It squares the counter with a shift-add multiplier and adds the square to an accumulator. The roles of the two sectors swap at every packet boundary, so bits can arrive on every clock cycle without a stall.

After reset, the block first spends 32 cycles zeroing both sectors. It then waits for a bit that carries both the valid flag and the sync flag. From that bit on, it counts packets back to back, with no gaps between them.

Top module: `poker_test`

## Requirements
- R1: While reset is high, and on the first cycle after reset falls, `ready_o` and `pass_o` are both 0.
- R2: Each run of four consecutive accepted bits forms one group. The first bit of the group has weight 8 and the last bit has weight 1. Each group adds one to the counter for its value, and a packet holds 5,000 groups.
- R3: Accepted bits are ignored until a cycle in which `bit_vld_i` and `pkt_sync_i` are both 1. That bit is the first bit of the first packet. A sync without valid has no effect. `ready_o` never rises before 20,000 accepted bits have been counted.
- R4: `ready_o` is high for exactly one cycle for each packet. `pass_o` takes its new value on that same edge and keeps it until the next pulse.
- R5: `pass_o` is 1 exactly when 1,563,175 < Σ f(i)² < 1,576,929 and every count is 428 or less. A count of 428 does not by itself fail the packet; a count of 429 fails it.
- R6: A counter stops at 511 instead of wrapping, and any packet that reaches 511 fails.
- R7: A `pkt_sync_i` pulse that arrives after the block is armed has no effect on grouping or on packet boundaries.
- R8: Cycles with `bit_vld_i` low are ignored, whatever the values on `bit_i` and `pkt_sync_i`.
- R9: Consecutive packets are independent. The counts of a packet never leak into the result of a later packet.
- R10: The result of a packet arrives within 1,000 cycles after its last bit, which is well before the next packet closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Random bit under test |
| bit_vld_i | input | 1 | Marks `bit_i` as a valid sample |
| pkt_sync_i | input | 1 | Together with a valid bit, arms the block; that bit starts the first packet |
| ready_o | output | 1 | One-cycle pulse when a packet result is available |
| pass_o | output | 1 | Result of the most recent packet (1 = pass) |

## Verification
The hardest cases to reach from the ports are packets whose sum of squares lands just inside a bound, or whose largest count sits exactly at 428 or 429. Random bits almost never produce these. The bench builds each packet from a chosen histogram of group values and sends the groups round robin, so it controls every count exactly. This lets it place the single-count limit on both sides of 428 and force a counter into saturation. It also sends a passing packet directly after a failing one to expose any leftover counts. Idle cycles and a stray sync are mixed in to test grouping alignment.

// File: rtl/poker_pkg.sv
package poker_pkg;
  typedef enum logic [2:0] {
    PS_SCRUB, PS_IDLE, PS_LOAD, PS_WAIT, PS_CLEAR, PS_MUL, PS_ACC, PS_EVAL
  } post_state_t;
endpackage

// File: rtl/poker_dpram.sv
// Two-port synchronous RAM holding both counter sectors.
module poker_dpram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic              a_we_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we_i) mem[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
    a_rdata_o <= mem[a_addr_i];
    b_rdata_o <= mem[b_addr_i];
  end
endmodule

// File: rtl/poker_nibble_ctr.sv
// Collects groups of bits and runs the read-increment-write on the incoming sector.
module poker_nibble_ctr #(
  parameter int NIB_W = 4,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             bit_i,
  input  logic             last_i,
  input  logic             sec_i,
  output logic [NIB_W:0]   ram_addr_o,
  output logic             ram_we_o,
  output logic [CNT_W-1:0] ram_wdata_o,
  input  logic [CNT_W-1:0] ram_rdata_i,
  output logic             done_o,
  output logic             done_sec_o
);
  localparam int PH_W   = $clog2(NIB_W);
  localparam int ADDR_W = NIB_W + 1;

  logic [NIB_W-2:0]  sh_q;
  logic [PH_W-1:0]   ph_q;
  logic              cap_v, cap_last;
  logic [ADDR_W-1:0] cap_addr;
  logic              s1_v, s1_last;
  logic [ADDR_W-1:0] s1_addr;
  logic              s2_v, s2_last;
  logic [ADDR_W-1:0] s2_addr;
  logic [CNT_W-1:0]  s2_data;
  logic [CNT_W-1:0]  inc_val;

  // Stage 0: shift in bits; the group is captured when its last bit arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      ph_q     <= '0;
      cap_v    <= 1'b0;
      cap_last <= 1'b0;
      cap_addr <= '0;
    end else begin
      cap_v <= 1'b0;
      if (en_i) begin
        if (ph_q == PH_W'(NIB_W-1)) begin
          ph_q     <= '0;
          cap_v    <= 1'b1;
          cap_last <= last_i;
          cap_addr <= {sec_i, sh_q, bit_i};
        end else begin
          ph_q <= ph_q + 1'b1;
          sh_q <= {sh_q[NIB_W-3:0], bit_i};
        end
      end
    end
  end

  // Stage 1: read issued while cap_v is high; the data returns during s1
  // Stage 2: increment with saturation; stage 3: write back
  assign inc_val = (&ram_rdata_i) ? ram_rdata_i : ram_rdata_i + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s1_addr <= '0;
      s2_v    <= 1'b0;
      s2_last <= 1'b0;
      s2_addr <= '0;
      s2_data <= '0;
    end else begin
      s1_v    <= cap_v;
      s1_last <= cap_last;
      s1_addr <= cap_addr;
      s2_v    <= s1_v;
      s2_last <= s1_last;
      s2_addr <= s1_addr;
      s2_data <= inc_val;
    end
  end

  assign ram_addr_o  = s2_v ? s2_addr : cap_addr;
  assign ram_we_o    = s2_v;
  assign ram_wdata_o = s2_data;
  assign done_o      = s2_v & s2_last;
  assign done_sec_o  = s2_addr[ADDR_W-1];
endmodule

// File: rtl/poker_sq_serial.sv
// Shift-add squarer: one multiplier bit per cycle.
module poker_sq_serial #(
  parameter int W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [W-1:0]   val_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int ST_W = $clog2(W + 1);

  logic [2*W-1:0] mcand;
  logic [W-1:0]   mplier;
  logic [ST_W-1:0] steps;
  logic           busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      steps  <= '0;
      busy   <= 1'b0;
      done_o <= 1'b0;
      prod_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        mcand  <= {{W{1'b0}}, val_i};
        mplier <= val_i;
        prod_o <= '0;
        steps  <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) prod_o <= prod_o + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        steps  <= steps + 1'b1;
        if (steps == ST_W'(W-1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/poker_post.sv
// Scrubs the RAM after reset, then evaluates and clears each finished sector.
module poker_post
  import poker_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int CNT_W     = 9,
  parameter int ACC_W     = 25,
  parameter int SUM_LO    = 1563175,
  parameter int SUM_HI    = 1576929,
  parameter int CNT_LIMIT = 428
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             start_sec_i,
  output logic [NIB_W:0]   ram_addr_o,
  output logic             ram_we_o,
  output logic [CNT_W-1:0] ram_wdata_o,
  input  logic [CNT_W-1:0] ram_rdata_i,
  output logic             busy_o,
  output logic             init_done_o,
  output logic             ready_o,
  output logic             pass_o
);
  localparam int ADDR_W = NIB_W + 1;

  post_state_t       state;
  logic [NIB_W-1:0]  idx;
  logic              sec_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc;
  logic              big;
  logic [ADDR_W-1:0] scrub_cnt;
  logic              sq_start, sq_done;
  logic [2*CNT_W-1:0] sq_prod;

  assign sq_start = (state == PS_CLEAR);

  poker_sq_serial #(.W(CNT_W)) sq_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (sq_start),
    .val_i   (cnt_q),
    .done_o  (sq_done),
    .prod_o  (sq_prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_SCRUB;
      idx       <= '0;
      sec_q     <= 1'b0;
      cnt_q     <= '0;
      acc       <= '0;
      big       <= 1'b0;
      scrub_cnt <= '0;
      ready_o   <= 1'b0;
      pass_o    <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      case (state)
        PS_SCRUB: begin
          scrub_cnt <= scrub_cnt + 1'b1;
          if (&scrub_cnt) state <= PS_IDLE;
        end
        PS_IDLE: begin
          if (start_i) begin
            sec_q <= start_sec_i;
            idx   <= '0;
            acc   <= '0;
            big   <= 1'b0;
            state <= PS_LOAD;
          end
        end
        PS_LOAD:  state <= PS_WAIT;
        PS_WAIT: begin
          cnt_q <= ram_rdata_i;
          state <= PS_CLEAR;
        end
        PS_CLEAR: state <= PS_MUL;
        PS_MUL:   if (sq_done) state <= PS_ACC;
        PS_ACC: begin
          acc <= acc + ACC_W'(sq_prod);
          big <= big | (cnt_q > CNT_W'(CNT_LIMIT));
          if (&idx) begin
            state <= PS_EVAL;
          end else begin
            idx   <= idx + 1'b1;
            state <= PS_LOAD;
          end
        end
        PS_EVAL: begin
          ready_o <= 1'b1;
          pass_o  <= !big && (acc > ACC_W'(SUM_LO)) && (acc < ACC_W'(SUM_HI));
          state   <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  assign ram_addr_o  = (state == PS_SCRUB) ? scrub_cnt : {sec_q, idx};
  assign ram_we_o    = (state == PS_SCRUB) || (state == PS_CLEAR);
  assign ram_wdata_o = '0;
  assign busy_o      = (state != PS_IDLE);
  assign init_done_o = (state != PS_SCRUB);
endmodule

// File: rtl/poker_test.sv
module poker_test #(
  parameter int PKT_BITS  = 20000,
  parameter int NIB_W     = 4,
  parameter int CNT_W     = 9,
  parameter int ACC_W     = 25,
  parameter int SUM_LO    = 1563175,
  parameter int SUM_HI    = 1576929,
  parameter int CNT_LIMIT = 428
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic bit_vld_i,
  input  logic pkt_sync_i,
  output logic ready_o,
  output logic pass_o
);
  localparam int ADDR_W = NIB_W + 1;
  localparam int BCNT_W = $clog2(PKT_BITS);

  logic              armed, in_sec, accept, last_bit;
  logic [BCNT_W-1:0] bit_cnt;
  logic              init_done, post_busy, pkt_done, done_sec;
  logic [ADDR_W-1:0] ram_addr_a, ram_addr_b;
  logic              ram_we_a, ram_we_b;
  logic [CNT_W-1:0]  ram_wdata_a, ram_wdata_b, ram_rdata_a, ram_rdata_b;

  assign accept   = bit_vld_i && (armed || (pkt_sync_i && init_done));
  assign last_bit = accept && (bit_cnt == BCNT_W'(PKT_BITS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      bit_cnt <= '0;
      in_sec  <= 1'b0;
    end else if (accept) begin
      armed <= 1'b1;
      if (last_bit) begin
        bit_cnt <= '0;
        in_sec  <= ~in_sec;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  poker_nibble_ctr #(.NIB_W(NIB_W), .CNT_W(CNT_W)) nib_i (
    .clk         (clk),
    .rst         (rst),
    .en_i        (accept),
    .bit_i       (bit_i),
    .last_i      (last_bit),
    .sec_i       (in_sec),
    .ram_addr_o  (ram_addr_a),
    .ram_we_o    (ram_we_a),
    .ram_wdata_o (ram_wdata_a),
    .ram_rdata_i (ram_rdata_a),
    .done_o      (pkt_done),
    .done_sec_o  (done_sec)
  );

  poker_post #(
    .NIB_W(NIB_W), .CNT_W(CNT_W), .ACC_W(ACC_W),
    .SUM_LO(SUM_LO), .SUM_HI(SUM_HI), .CNT_LIMIT(CNT_LIMIT)
  ) post_i (
    .clk         (clk),
    .rst         (rst),
    .start_i     (pkt_done),
    .start_sec_i (done_sec),
    .ram_addr_o  (ram_addr_b),
    .ram_we_o    (ram_we_b),
    .ram_wdata_o (ram_wdata_b),
    .ram_rdata_i (ram_rdata_b),
    .busy_o      (post_busy),
    .init_done_o (init_done),
    .ready_o     (ready_o),
    .pass_o      (pass_o)
  );

  poker_dpram #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) ram_i (
    .clk       (clk),
    .a_addr_i  (ram_addr_a),
    .a_we_i    (ram_we_a),
    .a_wdata_i (ram_wdata_a),
    .a_rdata_o (ram_rdata_a),
    .b_addr_i  (ram_addr_b),
    .b_we_i    (ram_we_b),
    .b_wdata_i (ram_wdata_b),
    .b_rdata_o (ram_rdata_b)
  );
endmodule

// File: rtl/poker_test_chk.sv
module poker_test_chk #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              ready_o,
  input logic              pass_o,
  input logic              pkt_done,
  input logic              post_busy,
  input logic              we_a,
  input logic [ADDR_W-1:0] addr_a,
  input logic [CNT_W-1:0]  wdata_a,
  input logic              we_b,
  input logic [ADDR_W-1:0] addr_b
);
  logic seen_done;

  always_ff @(posedge clk) begin
    if (rst) seen_done <= 1'b0;
    else if (pkt_done) seen_done <= 1'b1;
  end

  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  assert_pass_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pass_o) |-> ready_o);

  assert_no_early_ready_R3: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> seen_done);

  assert_post_idle_at_close_R10: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> !post_busy);

  assert_sector_clash_R9: assert property (@(posedge clk) disable iff (rst)
    (we_a && we_b) |-> (addr_a != addr_b));

  assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    we_a |-> (wdata_a != '0));
endmodule

bind poker_test poker_test_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ready_o   (ready_o),
  .pass_o    (pass_o),
  .pkt_done  (pkt_done),
  .post_busy (post_busy),
  .we_a      (ram_we_a),
  .addr_a    (ram_addr_a),
  .wdata_a   (ram_wdata_a),
  .we_b      (ram_we_b),
  .addr_b    (ram_addr_b)
);

// File: tb/poker_test_tb_top.sv
module poker_test_tb_top;
  localparam int NPKT = 7;
  // vector: {kind[2:0], gap, midsync, expected pass}
  // kind 0: 8 bins x332 + 8 bins x293 (S=1568584, pass)
  // kind 1: 8 bins x313 + 8 bins x312 (S=1562504, below low bound)
  // kind 2: 8 bins x352 + 8 bins x273 (S=1587464, above high bound)
  // kind 3: one bin 428, 12x305, 3x304 (S=1576732, pass at count limit)
  // kind 4: one bin 429, 11x305, 4x304 (count over limit, fail)
  // kind 5: one bin 600 (saturates at 511), 5x294, 10x293 (fail)
  localparam logic [5:0] VEC [NPKT] = '{
    {3'd0, 1'b0, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b0, 1'b0, 1'b0},
    {3'd1, 1'b0, 1'b0, 1'b0},
    {3'd5, 1'b0, 1'b0, 1'b0},
    {3'd3, 1'b0, 1'b1, 1'b1}
  };
  localparam string TAG [NPKT] = '{"R2", "R5", "R8_R9", "R5", "R5", "R6", "R7_R5"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_i = 1'b0, bit_vld_i = 1'b0, pkt_sync_i = 1'b0;
  logic ready_o, pass_o;

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int pkts_done = 0, res_idx = 0;
  int end_cyc [NPKT];
  int cnt [16];
  int rem [16];
  int pulse_err = 0, hold_err = 0;
  logic prev_ready = 1'b0, last_pass = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  poker_test dut_i (
    .clk        (clk),
    .rst        (rst),
    .bit_i      (bit_i),
    .bit_vld_i  (bit_vld_i),
    .pkt_sync_i (pkt_sync_i),
    .ready_o    (ready_o),
    .pass_o     (pass_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_counts(input int kind);
    for (int i = 0; i < 16; i++) begin
      case (kind)
        0: cnt[i] = (i % 2 == 0) ? 332 : 293;
        1: cnt[i] = (i % 2 == 0) ? 313 : 312;
        2: cnt[i] = (i % 2 == 0) ? 352 : 273;
        3: cnt[i] = (i == 0) ? 428 : ((i <= 12) ? 305 : 304);
        4: cnt[i] = (i == 0) ? 429 : ((i <= 11) ? 305 : 304);
        default: cnt[i] = (i == 5) ? 600 : ((i < 5) ? 294 : 293);
      endcase
    end
  endtask

  task automatic drive(input logic b, input logic v, input logic s);
    @(negedge clk);
    bit_i = b; bit_vld_i = v; pkt_sync_i = s;
  endtask

  task automatic send_packet(input int p);
    int v;
    set_counts(int'(VEC[p][5:3]));
    for (int i = 0; i < 16; i++) rem[i] = cnt[i];
    v = 15;
    for (int n = 0; n < 5000; n++) begin
      do v = (v + 1) % 16; while (rem[v] == 0);
      rem[v]--;
      for (int b = 3; b >= 0; b--) begin
        drive(v[b], 1'b1,
              ((p == 0) && (n == 0) && (b == 3)) ||
              (VEC[p][1] && (n == 1000) && (b == 2)));
      end
      if (VEC[p][2] && (n % 16 == 15)) drive(1'b1, 1'b0, 1'b1);
    end
    end_cyc[p] = cyc;
    pkts_done++;
  endtask

  // result monitor
  always @(negedge clk) begin
    if (rst) begin
      prev_ready = 1'b0;
      last_pass  = 1'b0;
    end else if (!finished) begin
      if (ready_o) begin
        if (prev_ready) pulse_err++;
        check(res_idx < pkts_done, "R3 early ready", res_idx, pkts_done);
        if (res_idx < pkts_done && res_idx < NPKT) begin
          check((cyc - end_cyc[res_idx]) <= 1000, "R10 latency",
                cyc - end_cyc[res_idx], 1000);
          check(pass_o == VEC[res_idx][0], TAG[res_idx], int'(pass_o), int'(VEC[res_idx][0]));
        end
        res_idx++;
        last_pass = pass_o;
      end else if (pass_o !== last_pass) begin
        hold_err++;
      end
      prev_ready = ready_o;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", res_idx, NPKT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ready_o == 1'b0, "R1 ready in reset", int'(ready_o), 0);
    check(pass_o == 1'b0, "R1 pass in reset", int'(pass_o), 0);
    @(negedge clk) rst = 1'b0;
    repeat (40) @(negedge clk);
    // R3/R8: bits before arming, and a sync without valid, are ignored
    for (int i = 0; i < 7; i++) drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b0);
    for (int p = 0; p < NPKT; p++) send_packet(p);
    drive(1'b0, 1'b0, 1'b0);
    for (int w = 0; w < 2000 && res_idx < NPKT; w++) @(negedge clk);
    check(res_idx == NPKT, "R4 one result per packet", res_idx, NPKT);
    check(pulse_err == 0, "R4 single-cycle ready", pulse_err, 0);
    check(hold_err == 0, "R4 pass held between pulses", hold_err, 0);
    // R1: reset after a passing result clears the outputs
    check(pass_o == 1'b1, "R5 last result held", int'(pass_o), 1);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check(pass_o == 1'b0, "R1 pass cleared by reset", int'(pass_o), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(ready_o == 1'b0 && pass_o == 1'b0, "R1 after reset",
          int'({ready_o, pass_o}), 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule